// File: doc/BRIEF.md
# Module Clock Control Handshake Controller

This block sits on the power-manager side of a single slave module and runs the idle handshake that decides when the slave's clocks may stop. Software selects a 2-bit module mode. Disabling the module raises an idle request to the slave at once. The request does not wait on any internal condition. The controller then holds both clocks running until the slave acknowledges. After the acknowledge it stops the interface clock. It stops the functional clock one cycle later, unless the slave is set up to run from a separate functional clock. Enabling the module drops the request and restarts both clocks straight away. The controller then waits for the slave to release its acknowledge before it reports the module as functional.

A 2-bit idle status output lets software watch this progress. The clock enables drive gating cells that sit outside this block. The mode comes from a register that also sits outside this block. All pins are plain control and status levels, with no data stream. Every output is decoded from one registered state, so each output moves on the first clock edge after the input that causes it.

Top module: `clkctl_handshake`

## Requirements
- R1: During and right after reset, the idle request is high, both clock enables are low and the idle status reads 3.
- R2: Mode code 0 (disable) raises the idle request on the next clock edge, whatever the acknowledge input is doing.
- R3: While the idle request is high and no acknowledge has been sampled, the interface clock enable stays high. On the edge that samples the acknowledge, the interface clock enable drops and the status becomes 2.
- R4: When the separate-functional-clock input is 0, the functional clock enable drops one edge after the interface clock enable and the status moves from 2 to 3.
- R5: When the separate-functional-clock input is 1, the functional clock enable stays high after the interface clock is gated, and the status stays at 2.
- R6: Mode code 2 (enable) lowers the idle request and raises both clock enables on the next clock edge. The status reads 1 for as long as the acknowledge stays high.
- R7: In the enable transition, the edge that samples the acknowledge low moves the status to 0 with both clocks running and the request low.
- R8: Mode codes 1 and 3 are reserved and change nothing: all outputs behave as they would under the last mode of 0 or 2 that was applied.
- R9: While waiting for the acknowledge after a disable, the status reads 1 and both clock enables stay high.
- R10: A disable that arrives while an enable transition is still waiting for the acknowledge to drop raises the request again on the next edge. The status stays at 1 and both clocks keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Module mode: 0 disable, 2 enable, 1 and 3 reserved |
| idle_ack_i | input | 1 | Idle acknowledge from the slave |
| sep_fclk_i | input | 1 | 1 when the slave may keep running on its own functional clock |
| idle_req_o | output | 1 | Idle request to the slave |
| iclk_en_o | output | 1 | Interface clock enable |
| fclk_en_o | output | 1 | Functional clock enable |
| idle_stat_o | output | 2 | 0 functional, 1 in transition, 2 interface idle, 3 full idle |

## Verification
The bench runs every scenario twice, once with the separate functional clock option off and once with it on. It checks the outputs after each edge against values derived from the requirements.

- **Ordering of the clock gating.** A design that gated the clocks on the request instead of on the acknowledge would show status 2 without any acknowledge. A design that stopped both clocks in one step would skip the status-2 cycle.
- **Reserved codes.** The bench applies them both in the functional state and in the idle state. A design that decoded code 1 or code 3 as a real mode would move the request or the clocks.
- **Disable during a wake.** The bench re-disables the module while the acknowledge is still high. A design that ignored the new disable would keep the request low.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int MODE_W = 2;
  localparam int STAT_W = 2;

  localparam logic [MODE_W-1:0] MODE_DIS = MODE_W'(0);
  localparam logic [MODE_W-1:0] MODE_EN  = MODE_W'(2);

  localparam logic [STAT_W-1:0] STAT_FUNC  = STAT_W'(0);
  localparam logic [STAT_W-1:0] STAT_TRANS = STAT_W'(1);
  localparam logic [STAT_W-1:0] STAT_IFIDL = STAT_W'(2);
  localparam logic [STAT_W-1:0] STAT_FULL  = STAT_W'(3);

  typedef enum logic [2:0] {
    HS_FULL_IDLE = 3'd0,
    HS_IF_IDLE   = 3'd1,
    HS_ACTIVE    = 3'd2,
    HS_SLP_WAIT  = 3'd3,
    HS_WAKE_WAIT = 3'd4
  } hs_state_t;

  typedef struct packed {
    logic              req;
    logic              iclk;
    logic              fclk;
    logic [STAT_W-1:0] stat;
  } hs_out_t;
endpackage

// File: rtl/clkctl_mode_hold.sv
module clkctl_mode_hold
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              want_on_o
);
  logic hold_q;
  logic is_dis, is_en;

  assign is_dis = (mode_i == MODE_DIS);
  assign is_en  = (mode_i == MODE_EN);

  // reserved codes fall through to the last legal choice
  always_comb begin
    if (is_en)       want_on_o = 1'b1;
    else if (is_dis) want_on_o = 1'b0;
    else             want_on_o = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= want_on_o;
  end
endmodule

// File: rtl/clkctl_hs_fsm.sv
module clkctl_hs_fsm
  import clkctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want_on_i,
  input  logic      ack_i,
  input  logic      sep_fclk_i,
  output hs_state_t state_o
);
  hs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_ACTIVE:    if (!want_on_i) state_d = HS_SLP_WAIT;
      HS_SLP_WAIT: begin
        if (want_on_i)  state_d = HS_WAKE_WAIT;
        else if (ack_i) state_d = HS_IF_IDLE;
      end
      HS_IF_IDLE: begin
        if (want_on_i)        state_d = HS_WAKE_WAIT;
        else if (!sep_fclk_i) state_d = HS_FULL_IDLE;
      end
      HS_FULL_IDLE: if (want_on_i) state_d = HS_WAKE_WAIT;
      HS_WAKE_WAIT: begin
        if (!want_on_i) state_d = HS_SLP_WAIT;
        else if (!ack_i) state_d = HS_ACTIVE;
      end
      default: state_d = HS_FULL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_FULL_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R10
  wake_redisable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_WAKE_WAIT && !want_on_i) |=> (state_q == HS_SLP_WAIT));

  // R3
  no_gate_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_SLP_WAIT && !ack_i && !want_on_i) |=> (state_q == HS_SLP_WAIT));
endmodule

// File: rtl/clkctl_out_dec.sv
module clkctl_out_dec
  import clkctl_pkg::*;
(
  input  hs_state_t state_i,
  output hs_out_t   out_o
);
  always_comb begin
    out_o = '{req: 1'b1, iclk: 1'b0, fclk: 1'b0, stat: STAT_FULL};
    unique case (state_i)
      HS_ACTIVE:    out_o = '{req: 1'b0, iclk: 1'b1, fclk: 1'b1, stat: STAT_FUNC};
      HS_SLP_WAIT:  out_o = '{req: 1'b1, iclk: 1'b1, fclk: 1'b1, stat: STAT_TRANS};
      HS_WAKE_WAIT: out_o = '{req: 1'b0, iclk: 1'b1, fclk: 1'b1, stat: STAT_TRANS};
      HS_IF_IDLE:   out_o = '{req: 1'b1, iclk: 1'b0, fclk: 1'b1, stat: STAT_IFIDL};
      HS_FULL_IDLE: out_o = '{req: 1'b1, iclk: 1'b0, fclk: 1'b0, stat: STAT_FULL};
      default:      out_o = '{req: 1'b1, iclk: 1'b0, fclk: 1'b0, stat: STAT_FULL};
    endcase
  end
endmodule

// File: rtl/clkctl_handshake.sv
module clkctl_handshake
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              idle_ack_i,
  input  logic              sep_fclk_i,
  output logic              idle_req_o,
  output logic              iclk_en_o,
  output logic              fclk_en_o,
  output logic [STAT_W-1:0] idle_stat_o
);
  logic      want_on;
  hs_state_t state;
  hs_out_t   outs;

  clkctl_mode_hold u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .want_on_o (want_on)
  );

  clkctl_hs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_on_i  (want_on),
    .ack_i      (idle_ack_i),
    .sep_fclk_i (sep_fclk_i),
    .state_o    (state)
  );

  clkctl_out_dec u_dec (
    .state_i (state),
    .out_o   (outs)
  );

  assign idle_req_o  = outs.req;
  assign iclk_en_o   = outs.iclk;
  assign fclk_en_o   = outs.fclk;
  assign idle_stat_o = outs.stat;

  // R2
  disable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_DIS) |=> idle_req_o);

  // R6
  enable_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_EN) |=> (!idle_req_o && iclk_en_o && fclk_en_o));

  // R3
  iclk_gate_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iclk_en_o) |-> ($past(idle_ack_i) && $past(idle_req_o)));

  // R4
  fclk_after_iclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fclk_en_o) |-> ($past(!iclk_en_o) && $past(!sep_fclk_i)));

  // R5
  sep_fclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_stat_o == STAT_IFIDL && sep_fclk_i && mode_i != MODE_EN && !want_on)
      |=> fclk_en_o);
endmodule

// File: tb/clkctl_handshake_tb.sv
module clkctl_handshake_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       idle_ack_i = 1'b0;
  logic       sep_fclk_i = 1'b0;
  logic       idle_req_o, iclk_en_o, fclk_en_o;
  logic [1:0] idle_stat_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clkctl_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .idle_ack_i(idle_ack_i),
    .sep_fclk_i(sep_fclk_i), .idle_req_o(idle_req_o), .iclk_en_o(iclk_en_o),
    .fclk_en_o(fclk_en_o), .idle_stat_o(idle_stat_o)
  );

  task automatic chk(input string tag, input logic req, input logic ic,
                     input logic fc, input logic [1:0] st);
    logic [4:0] got, exp;
    got = {idle_req_o, iclk_en_o, fclk_en_o, idle_stat_o};
    exp = {req, ic, fc, st};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {req,iclk,fclk,stat} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic a, input logic s);
    mode_i = m; idle_ack_i = a; sep_fclk_i = s;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; mode_i = 2'd0; idle_ack_i = 1'b0; sep_fclk_i = s;
    @(negedge clk);
    chk("R1 in reset", 1'b1, 1'b0, 1'b0, 2'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b1, 1'b0, 1'b0, 2'd3);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      logic sp;
      sp = s[0];
      do_reset(sp);
      // wake from full idle with slave still acknowledging
      step(2'd2, 1'b1, sp); chk("R6 wake ack high", 1'b0, 1'b1, 1'b1, 2'd1);
      step(2'd2, 1'b1, sp); chk("R6 wake hold", 1'b0, 1'b1, 1'b1, 2'd1);
      step(2'd2, 1'b0, sp); chk("R7 ack released", 1'b0, 1'b1, 1'b1, 2'd0);
      // reserved codes in functional state
      for (int r = 0; r < 2; r++) begin
        step(r ? 2'd3 : 2'd1, 1'b0, sp);
        chk("R8 reserved while on", 1'b0, 1'b1, 1'b1, 2'd0);
      end
      // disable, slave slow to acknowledge
      step(2'd0, 1'b0, sp); chk("R2 disable req", 1'b1, 1'b1, 1'b1, 2'd1);
      for (int w = 0; w < 3; w++) begin
        step(2'd0, 1'b0, sp); chk("R9 waiting ack", 1'b1, 1'b1, 1'b1, 2'd1);
      end
      step(2'd1, 1'b0, sp); chk("R3 no ack yet (reserved)", 1'b1, 1'b1, 1'b1, 2'd1);
      step(2'd0, 1'b1, sp); chk("R3 ack gates iclk", 1'b1, 1'b0, 1'b1, 2'd2);
      step(2'd0, 1'b1, sp);
      if (sp) chk("R5 separate fclk kept", 1'b1, 1'b0, 1'b1, 2'd2);
      else    chk("R4 fclk gated", 1'b1, 1'b0, 1'b0, 2'd3);
      for (int r = 0; r < 2; r++) begin
        step(r ? 2'd3 : 2'd1, 1'b1, sp);
        if (sp) chk("R8 reserved while idle", 1'b1, 1'b0, 1'b1, 2'd2);
        else    chk("R8 reserved while idle", 1'b1, 1'b0, 1'b0, 2'd3);
      end
      // wake then disable again before ack drops
      step(2'd2, 1'b1, sp); chk("R6 wake from idle", 1'b0, 1'b1, 1'b1, 2'd1);
      step(2'd0, 1'b1, sp); chk("R10 redisable in wake", 1'b1, 1'b1, 1'b1, 2'd1);
      step(2'd0, 1'b1, sp); chk("R3 ack seen after redisable", 1'b1, 1'b0, 1'b1, 2'd2);
      // enable with a reserved code in between, then release ack
      step(2'd2, 1'b1, sp); chk("R6 wake again", 1'b0, 1'b1, 1'b1, 2'd1);
      step(2'd1, 1'b0, sp); chk("R8 reserved keeps enable", 1'b0, 1'b1, 1'b1, 2'd0);
      // disable with ack already high: request regardless of ack
      step(2'd0, 1'b1, sp); chk("R2 disable ack high", 1'b1, 1'b1, 1'b1, 2'd1);
      step(2'd0, 1'b1, sp); chk("R3 immediate ack", 1'b1, 1'b0, 1'b1, 2'd2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule